// File: doc/BRIEF.md
# Subvector Pack/Unpack Index Sequencer

This block drives the addressing side of a vector move whose elements are short subvectors of one to four lanes. A start strobe captures a vector length, a subvector length and two order selects. The block then hands out one pair of element offsets per accepted transfer: an offset to read from and an offset to write to. A consumer turns each pair into a single element copy.

Each side has its own walker. Both walkers step through the same logical (element, lane) sequence: element index outer, lane index inner. The order select decides how that position becomes an offset. In element-major order the offset is element times lanes plus lane. In lane-major order the offset is element plus vector length times lane, so the subvector lanes are gathered into planes.

The source side uses lane-major order when pack is enabled. The destination side uses lane-major order when unpack is enabled. Both enables may be set together, and each side is then transposed independently. When the last pair has been taken, the block raises a single-cycle done pulse.

Top module: `subvec_index_seq`

## Requirements
- R1: After reset, `pair_valid_o` and `done_o` are both low.
- R2: A start accepted while idle gives `pair_valid_o` high in the next cycle, with both offsets equal to 0, when the clamped vector length is not zero.
- R3: With the side's enable clear, pair number k carries offset k on that side, which is the element-major value i*S+j. Here i = k / S, j = k % S, and S is the lane count.
- R4: With `pack_en_i` set, the source offset of pair k is i + V*j, where V is the clamped vector length.
- R5: With `unpack_en_i` set, the destination offset of pair k is i + V*j, whatever `pack_en_i` is. With both enables set, both sides are transposed.
- R6: A run hands out exactly V*S pairs, one per cycle in which valid and ready are both high. In the cycle after the last transfer, `pair_valid_o` is low and `done_o` is high for exactly one cycle.
- R7: A start with `vl_i` = 0 produces no pairs, and raises `done_o` in the next cycle.
- R8: While `pair_valid_o` is high and `pair_ready_i` is low, the valid signal and both offsets hold their values into the next cycle.
- R9: A start during a run (while `pair_valid_o` is high) is ignored. The run continues with its captured configuration and pair count.
- R10: `subvl_code_i` encodes the lane count as S = code + 1 (0 gives 1 lane, 3 gives 4 lanes). With S = 1, both orders give the sequence 0..V-1.
- R11: A `vl_i` above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures the configuration when idle |
| vl_i | input | 7 | Vector length in elements (0..127, clamped to 64) |
| subvl_code_i | input | 2 | Lane count minus one |
| pack_en_i | input | 1 | Source side walks lane-major order |
| unpack_en_i | input | 1 | Destination side walks lane-major order |
| pair_valid_o | output | 1 | An offset pair is presented |
| pair_ready_i | input | 1 | Consumer takes the presented pair |
| src_off_o | output | 8 | Source element offset |
| dst_off_o | output | 8 | Destination element offset |
| done_o | output | 1 | One-cycle pulse after the final pair, or after an empty run |

## Verification
A walker whose lane or element counter drifts shows a wrong offset in the very next transfer after the fault. The bench compares every transferred pair against an offset computed from i and j, so the error is caught at that transfer. A wrong wrap of the row base shows up at the first element boundary, which for two lanes is the third pair. A miscounted end shows as done arriving one transfer early or late, or as valid still high beside done. A fault in capture or stall handling shows as offsets moving while ready is low, or as the sequence changing after a start strobe in mid-run.

// File: rtl/psu_pkg.sv
package psu_pkg;

   // Lane count is carried as (lanes - 1); four lanes at most.
   localparam int LANE_CODE_W = 2;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef enum logic {
      ORD_ELEM = 1'b0,   // offset = i*S + j
      ORD_LANE = 1'b1    // offset = i + V*j
   } walk_order_e;

   function automatic logic [2:0] lanes_from_code(input logic [LANE_CODE_W-1:0] code);
      return {1'b0, code} + 3'd1;
   endfunction

endpackage

// File: rtl/psu_walker.sv
module psu_walker
   import psu_pkg::*;
#(
   parameter int VL_W        = 7,
   parameter int LANE_W      = 3,
   parameter int OFF_W       = 8,
   parameter bit INCREMENTAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  walk_order_e       order_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [LANE_W-1:0] lanes_i,
   output logic [OFF_W-1:0]  off_o,
   output logic              last_o
);

   localparam int J_W = (LANE_W > 1) ? LANE_W - 1 : 1;

   logic [VL_W-1:0] elem_q;
   logic [J_W-1:0]  lane_q;
   logic            lane_wrap;
   logic            elem_last;

   assign lane_wrap = (LANE_W'(lane_q) == LANE_W'(lanes_i - 1'b1));
   assign elem_last = (elem_q == VL_W'(vl_i - 1'b1));
   assign last_o    = lane_wrap && elem_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem_q <= '0;
         lane_q <= '0;
      end else if (load_i) begin
         elem_q <= '0;
         lane_q <= '0;
      end else if (adv_i) begin
         if (lane_wrap) begin
            lane_q <= '0;
            elem_q <= elem_q + 1'b1;
         end else begin
            lane_q <= lane_q + 1'b1;
         end
      end
   end

   generate
      if (INCREMENTAL) begin : g_incr
         logic [OFF_W-1:0] off_q;
         logic [OFF_W-1:0] base_q;
         logic [OFF_W-1:0] lane_step;
         logic [OFF_W-1:0] row_step;

         always_comb begin
            if (order_i == ORD_LANE) begin
               lane_step = OFF_W'(vl_i);
               row_step  = OFF_W'(1);
            end else begin
               lane_step = OFF_W'(1);
               row_step  = OFF_W'(lanes_i);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               off_q  <= '0;
               base_q <= '0;
            end else if (load_i) begin
               off_q  <= '0;
               base_q <= '0;
            end else if (adv_i) begin
               if (lane_wrap) begin
                  base_q <= base_q + row_step;
                  off_q  <= base_q + row_step;
               end else begin
                  off_q  <= off_q + lane_step;
               end
            end
         end

         assign off_o = off_q;

         // R4: the running sum agrees with the closed-form offset of (i, j)
         a_r4_incr_matches_form: assert property (@(posedge clk) disable iff (!rst_n)
            adv_i |-> off_q == ((order_i == ORD_LANE)
                                ? OFF_W'(OFF_W'(elem_q) + OFF_W'(vl_i) * OFF_W'(lane_q))
                                : OFF_W'(OFF_W'(elem_q) * OFF_W'(lanes_i) + OFF_W'(lane_q))));
      end else begin : g_mult
         always_comb begin
            if (order_i == ORD_LANE)
               off_o = OFF_W'(OFF_W'(elem_q) + OFF_W'(vl_i) * OFF_W'(lane_q));
            else
               off_o = OFF_W'(OFF_W'(elem_q) * OFF_W'(lanes_i) + OFF_W'(lane_q));
         end
      end
   endgenerate

   // R6: an advance never happens past the last element
   a_r6_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> elem_q < vl_i);

   // R10: the lane counter stays below the lane count
   a_r10_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> LANE_W'(lane_q) < lanes_i);

endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl
   import psu_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int VL_W   = 7,
   parameter int LANE_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [VL_W-1:0]        vl_i,
   input  logic [LANE_CODE_W-1:0] lane_code_i,
   input  logic                   pack_i,
   input  logic                   unpack_i,
   input  logic                   ready_i,
   input  logic                   last_i,
   output logic                   load_o,
   output logic                   adv_o,
   output logic                   valid_o,
   output logic                   done_o,
   output logic [VL_W-1:0]        vl_o,
   output logic [LANE_W-1:0]      lanes_o,
   output walk_order_e            src_order_o,
   output walk_order_e            dst_order_o
);

   seq_state_e        state_q;
   logic              done_q;
   logic [VL_W-1:0]   vl_q;
   logic [LANE_W-1:0] lanes_q;
   walk_order_e       src_ord_q;
   walk_order_e       dst_ord_q;
   logic [VL_W-1:0]   vl_clamped;
   logic              accept;
   logic              fire;

   assign vl_clamped = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
   assign accept     = start_i && (state_q == SEQ_IDLE);
   assign valid_o    = (state_q == SEQ_RUN);
   assign fire       = valid_o && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         done_q    <= 1'b0;
         vl_q      <= '0;
         lanes_q   <= LANE_W'(1);
         src_ord_q <= ORD_ELEM;
         dst_ord_q <= ORD_ELEM;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            vl_q      <= vl_clamped;
            lanes_q   <= LANE_W'(lanes_from_code(lane_code_i));
            src_ord_q <= pack_i   ? ORD_LANE : ORD_ELEM;
            dst_ord_q <= unpack_i ? ORD_LANE : ORD_ELEM;
            if (vl_clamped == '0) done_q  <= 1'b1;
            else                  state_q <= SEQ_RUN;
         end else if (fire && last_i) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
         end
      end
   end

   assign load_o      = accept;
   assign adv_o       = fire;
   assign done_o      = done_q;
   assign vl_o        = vl_q;
   assign lanes_o     = lanes_q;
   assign src_order_o = src_ord_q;
   assign dst_order_o = dst_ord_q;

   // R8: a presented pair is not withdrawn until taken
   a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o);

   // R9: a strobe in mid-run leaves the captured configuration alone
   a_r9_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && start_i |=> $stable(vl_q) && $stable(lanes_q)
                             && $stable(src_ord_q) && $stable(dst_ord_q));

   // R6: done and valid never overlap
   a_r6_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);

   // R11: the captured length never exceeds the ceiling
   a_r11_vl_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= VL_W'(MAX_VL));

endmodule

// File: rtl/subvec_index_seq.sv
module subvec_index_seq
   import psu_pkg::*;
#(
   parameter int MAX_VL      = 64,
   parameter int MAX_LANES   = 4,
   parameter int OFF_W       = 8,
   parameter bit INCREMENTAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [6:0]       vl_i,
   input  logic [1:0]       subvl_code_i,
   input  logic             pack_en_i,
   input  logic             unpack_en_i,
   output logic             pair_valid_o,
   input  logic             pair_ready_i,
   output logic [OFF_W-1:0] src_off_o,
   output logic [OFF_W-1:0] dst_off_o,
   output logic             done_o
);

   localparam int VL_W    = $clog2(MAX_VL + 1);
   localparam int LANE_W  = $clog2(MAX_LANES + 1);
   localparam int CNT_W   = OFF_W + 1;
   localparam int N_SIDES = 2;

   generate
      if (MAX_LANES != 4) begin : g_bad_lanes
         $error("subvec_index_seq: lane code is two bits, MAX_LANES must be 4");
      end
      if (VL_W != 7) begin : g_bad_vl
         $error("subvec_index_seq: vl_i port is 7 bits wide, MAX_VL must be 64..127");
      end
      if (OFF_W < $clog2(MAX_VL * MAX_LANES)) begin : g_bad_off
         $error("subvec_index_seq: OFF_W too narrow for MAX_VL*MAX_LANES offsets");
      end
   endgenerate

   logic              load;
   logic              adv;
   logic [VL_W-1:0]   vl_q;
   logic [LANE_W-1:0] lanes_q;
   walk_order_e       src_ord;
   walk_order_e       dst_ord;
   walk_order_e       side_ord [N_SIDES];
   logic [OFF_W-1:0]  side_off [N_SIDES];
   logic              side_last [N_SIDES];

   psu_ctrl #(
      .MAX_VL (MAX_VL),
      .VL_W   (VL_W),
      .LANE_W (LANE_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vl_i        (vl_i),
      .lane_code_i (subvl_code_i),
      .pack_i      (pack_en_i),
      .unpack_i    (unpack_en_i),
      .ready_i     (pair_ready_i),
      .last_i      (side_last[0]),
      .load_o      (load),
      .adv_o       (adv),
      .valid_o     (pair_valid_o),
      .done_o      (done_o),
      .vl_o        (vl_q),
      .lanes_o     (lanes_q),
      .src_order_o (src_ord),
      .dst_order_o (dst_ord)
   );

   assign side_ord[0] = src_ord;
   assign side_ord[1] = dst_ord;

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         psu_walker #(
            .VL_W        (VL_W),
            .LANE_W      (LANE_W),
            .OFF_W       (OFF_W),
            .INCREMENTAL (INCREMENTAL)
         ) walker_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .adv_i   (adv),
            .order_i (side_ord[s]),
            .vl_i    (vl_q),
            .lanes_i (lanes_q),
            .off_o   (side_off[s]),
            .last_o  (side_last[s])
         );
      end
   endgenerate

   assign src_off_o = side_off[0];
   assign dst_off_o = side_off[1];

   // Transfer counter for the pair-count property.
   logic [CNT_W-1:0] xfer_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    xfer_cnt <= '0;
      else if (load) xfer_cnt <= '0;
      else if (adv)  xfer_cnt <= xfer_cnt + 1'b1;
   end

   // R6: done follows exactly V*S transfers
   a_r6_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> xfer_cnt == CNT_W'(CNT_W'(vl_q) * CNT_W'(lanes_q)));

   // R5: the two walkers stay in lock-step
   a_r5_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      side_last[0] == side_last[1]);

   // R2: a fresh run opens at offset zero on both sides
   a_r2_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_valid_o) |-> src_off_o == '0 && dst_off_o == '0);

   // R8: offsets hold while stalled
   a_r8_offsets_held: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid_o && !pair_ready_i |=> $stable(src_off_o) && $stable(dst_off_o));

endmodule

// File: tb/subvec_index_seq_tb_top.sv
module subvec_index_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] vl_in = '0;
   logic [1:0] code_in = '0;
   logic       pack_in = 1'b0;
   logic       unpack_in = 1'b0;
   logic       ready = 1'b0;
   logic       valid;
   logic [7:0] src_off;
   logic [7:0] dst_off;
   logic       done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   subvec_index_seq dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .vl_i         (vl_in),
      .subvl_code_i (code_in),
      .pack_en_i    (pack_in),
      .unpack_en_i  (unpack_in),
      .pair_valid_o (valid),
      .pair_ready_i (ready),
      .src_off_o    (src_off),
      .dst_off_o    (dst_off),
      .done_o       (done)
   );

   // Vector fields: {vl[6:0], code[1:0], pack, unpack, stall, poke}
   localparam int N_VEC = 12;
   localparam logic [12:0] VEC [N_VEC] = '{
      {7'd4,   2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 both element-major
      {7'd4,   2'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 pack
      {7'd4,   2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 unpack
      {7'd4,   2'd1, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 both
      {7'd3,   2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 stalls, 3 lanes
      {7'd5,   2'd3, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 stalls, 4 lanes
      {7'd6,   2'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R10 single lane
      {7'd1,   2'd3, 1'b1, 1'b1, 1'b0, 1'b0},  // one element
      {7'd64,  2'd3, 1'b1, 1'b0, 1'b0, 1'b0},  // largest run
      {7'd100, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R11 clamp
      {7'd3,   2'd1, 1'b0, 1'b0, 1'b0, 1'b1},  // R9 strobe in run
      {7'd7,   2'd2, 1'b1, 1'b1, 1'b1, 1'b1}   // R9 with stalls
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input logic [12:0] v);
      int vv, ss, total, k, cyc, guard;
      int ps, pd;
      bit pk, st, p, u, first, done_seen, poked, prev_stall;
      vv = (int'(v[12:6]) > 64) ? 64 : int'(v[12:6]);
      ss = int'(v[5:4]) + 1;
      p = v[3]; u = v[2]; st = v[1]; pk = v[0];
      total = vv * ss;
      @(negedge clk);
      start = 1'b1; vl_in = v[12:6]; code_in = v[5:4];
      pack_in = p; unpack_in = u; ready = 1'b0;
      @(negedge clk);
      start = 1'b0; vl_in = 7'd9; code_in = ~v[5:4]; pack_in = ~p; unpack_in = ~u;
      first = 1'b1; done_seen = 1'b0; poked = 1'b0; prev_stall = 1'b0;
      k = 0; cyc = 0; guard = 0; ps = 0; pd = 0;
      while (!done_seen && guard < 3000) begin
         guard++;
         start = 1'b0;
         if (first) begin
            first = 1'b0;
            if (total > 0)
               chk(valid && src_off == 0 && dst_off == 0, "R2 first pair",
                   int'(src_off), 0);
         end
         if (done) begin
            done_seen = 1'b1;
            chk(!valid, "R6 valid low with done", int'(valid), 0);
            chk(k == total, "R6 pair count", k, total);
         end else if (valid) begin
            if (prev_stall) begin
               chk(int'(src_off) == ps, "R8 src held", int'(src_off), ps);
               chk(int'(dst_off) == pd, "R8 dst held", int'(dst_off), pd);
            end
            ready = st ? (cyc % 3 != 1) : 1'b1;
            if (ready) begin
               int ei, lj, es, ed;
               ei = k / ss; lj = k % ss;
               es = p ? ei + vv * lj : k;
               ed = u ? ei + vv * lj : k;
               chk(int'(src_off) == es, p ? "R4 src lane-major" : "R3 src element-major",
                   int'(src_off), es);
               chk(int'(dst_off) == ed, u ? "R5 dst lane-major" : "R3 dst element-major",
                   int'(dst_off), ed);
               if (ss == 1) chk(src_off == dst_off, "R10 single lane orders agree",
                                int'(src_off), int'(dst_off));
               k++;
            end
            prev_stall = !ready;
            ps = int'(src_off); pd = int'(dst_off);
            if (pk && k == 2 && !poked) begin
               poked = 1'b1;
               start = 1'b1; vl_in = 7'd5; code_in = 2'd3; pack_in = ~p; unpack_in = ~u;
            end
         end
         cyc++;
         @(negedge clk);
      end
      start = 1'b0; ready = 1'b0;
      chk(done_seen, pk ? "R9 run completes after strobe" : "R6 done seen",
          int'(done_seen), 1);
      chk(!done && !valid, "R6 done lasts one cycle", int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(!valid && !done, "R1 reset state", int'({valid, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid && !done, "R1 idle after reset", int'({valid, done}), 0);

      for (int n = 0; n < N_VEC; n++) run_vec(VEC[n]);

      // R7: empty run
      @(negedge clk);
      start = 1'b1; vl_in = 7'd0; code_in = 2'd2; pack_in = 1'b1; unpack_in = 1'b0;
      ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !valid, "R7 empty run done next cycle", int'({done, valid}), 2);
      @(negedge clk);
      chk(!done && !valid, "R7 no pairs after empty run", int'({done, valid}), 0);
      repeat (3) begin
         @(negedge clk);
         chk(!valid, "R7 stays idle", int'(valid), 0);
      end
      ready = 1'b0;

      // R8 directed: long stall at the first pair
      @(negedge clk);
      start = 1'b1; vl_in = 7'd2; code_in = 2'd1; pack_in = 1'b1; unpack_in = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) begin
         @(negedge clk);
         chk(valid && src_off == 0 && dst_off == 0, "R8 long stall hold",
             int'(src_off), 0);
      end
      ready = 1'b1;
      @(negedge clk);
      chk(src_off == 8'd2 && dst_off == 8'd2, "R5 second pair both transposed",
          int'(src_off), 2);
      repeat (3) @(negedge clk);
      chk(done && !valid, "R6 done after last pair", int'(done), 1);
      ready = 1'b0;
      @(negedge clk);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule